// File: doc/BRIEF.md
# Scrolling Display Address Generator

This block turns the first visible row of a vertically scrolling monochrome LED window into serial-memory read addresses and a bit-select value. The virtual picture is four panel heights tall and is cut into four display blocks. Each block is stored as `SCAN_SP` partitions of `PANEL_W` bytes. Each byte carries one pixel for each of the eight scan lines at one column, and the scan lines are `SCAN_SP` rows apart. The memory interleaves two copies of the blocks. Even bytes hold the blocks in their natural order, and odd bytes hold the same blocks rotated forward by one. A 16-bit read at an even address therefore returns two neighbouring blocks, and `bitSel` tells the downstream shifter how many leading bits to drop so that eight contiguous scan lines remain.

A `loadRow` pulse captures `startRow`. The block splits the row into block, bit offset and partition using repeated subtraction of `SCAN_SP`. While it works, `ready` is low. After that, `colStep` walks the columns of the current partition. `rowStep` moves the window down by one row and returns the column to zero. When the row leaves the last partition, the address falls back to the start of the block and `bitSel` moves up by one. The row wraps through all four blocks.

Top module: `scroll_addr_gen`

## Requirements
- R1: During and after reset, with no strobes applied, `ready` is 1, `memAddr` is 0 and `bitSel` is 0.
- R2: A `loadRow` sampled on a rising edge drives `ready` low on that edge. `ready` comes back high on the (floor(startRow/SCAN_SP)+2)-th rising edge, counting the edge that sampled `loadRow` as the first.
- R3: When ready, `memAddr` = 2·(blk·SCAN_SP·PANEL_W + (row mod SCAN_SP)·PANEL_W + col). Here blk = floor(row/(8·SCAN_SP)) mod 4 and col is the column counter. A load sets the column counter to 0, so the address is always even.
- R4: When ready, `bitSel` = floor((row mod 8·SCAN_SP)/SCAN_SP), a value from 0 to 7.
- R5: A `colStep` alone in a ready cycle raises the column counter by one, which adds 2 to `memAddr`.
- R6: A `colStep` at column PANEL_W-1 returns the column to 0 in the same partition.
- R7: A `rowStep` in a ready cycle advances the row by one and sets the column to 0. From partition SCAN_SP-1 it goes back to partition 0, which is the block start address, and raises `bitSel` by one.
- R8: A `rowStep` from bit offset 7 and partition SCAN_SP-1 enters the next block with `bitSel` 0. A step from the last row of the fourth block returns to row 0.
- R9: When `rowStep` and `colStep` arrive in the same ready cycle, only the row step takes effect.
- R10: While `ready` is low, `rowStep` and `colStep` have no effect, and the result after the load is that of the loaded row at column 0.
- R11: `loadRow` takes priority over `rowStep` and `colStep` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadRow | input | 1 | Capture startRow and begin the split |
| startRow | input | ROW_W | First visible row of the window |
| rowStep | input | 1 | Move the window one row down |
| colStep | input | 1 | Advance to the next column |
| ready | output | 1 | Position valid, strobes accepted |
| memAddr | output | ADDR_W | Even byte address of the 16-bit read |
| bitSel | output | 3 | Number of leading bits to skip |

## Verification
Random start rows cover every block, partition and bit offset, and the check on the busy time separates a correct subtraction count from an off-by-one. Random mixes of the column and row strobes, including both at once, test the column increment, the row-over-column priority and the reload to column 0. Directed cases cover the boundaries: column wrap at the panel width, the partition wrap that returns to the block start, the block crossing at bit offset 7, the wrap from the last row to row 0, strobes issued during the busy time, and strobes issued together with a load.

// File: rtl/scroll_addr_pkg.sv
package scroll_addr_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic start;    // capture start row, clear quotient
    logic divStep;  // subtract one scan spacing
    logic divDone;  // latch block / offset / partition
    logic rowAdv;   // advance one row
    logic colAdv;   // advance one column
  } dpCtrl_t;

  typedef enum logic [0:0] {ST_IDLE, ST_DIV} ctrlState_t;
endpackage

// File: rtl/scroll_ctrl.sv
module scroll_ctrl
  import scroll_addr_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    loadRow,
  input  logic    rowStep,
  input  logic    colStep,
  input  logic    remGeSw,
  output dpCtrl_t ctrl,
  output logic    ready
);
  ctrlState_t state;

  always_comb begin
    ctrl  = '0;
    ready = (state == ST_IDLE);
    ctrl.start = loadRow;
    if (!loadRow) begin
      if (state == ST_DIV) begin
        ctrl.divStep = remGeSw;
        ctrl.divDone = !remGeSw;
      end else begin
        ctrl.rowAdv = rowStep;
        ctrl.colAdv = colStep && !rowStep;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else if (ctrl.start) begin
      state <= ST_DIV;
    end else if (ctrl.divDone) begin
      state <= ST_IDLE;
    end
  end
endmodule

// File: rtl/scroll_dp.sv
module scroll_dp
  import scroll_addr_pkg::*;
#(
  parameter int PANEL_W = 16,
  parameter int SCAN_SP = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpCtrl_t               ctrl,
  input  logic [ROW_W-1:0]      startRow,
  output logic                  remGeSw,
  output logic [COL_W-1:0]      colIdx,
  output logic [PART_W-1:0]     partIdx,
  output logic [2:0]            bitSel,
  output logic [ADDR_W-1:0]     memAddr
);
  localparam int BLK_ROWS   = 8 * SCAN_SP;
  localparam int ROW_W      = $clog2(4 * BLK_ROWS);
  localparam int COL_W      = (PANEL_W > 1) ? $clog2(PANEL_W) : 1;
  localparam int PART_W     = (SCAN_SP > 1) ? $clog2(SCAN_SP) : 1;
  localparam int BLK_BYTES  = SCAN_SP * PANEL_W;
  localparam int ADDR_W     = $clog2(8 * BLK_BYTES);
  localparam int LOG_W      = ADDR_W - 1;

  logic [ROW_W-1:0]  remR;
  logic [ROW_W-1:0]  quoR;
  logic [PART_W-1:0] partR;
  logic [2:0]        bitR;
  logic [1:0]        blkR;
  logic [COL_W-1:0]  colR;
  logic [LOG_W-1:0]  logicalIdx;

  assign remGeSw = remR >= ROW_W'(SCAN_SP);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remR  <= '0;
      quoR  <= '0;
      partR <= '0;
      bitR  <= '0;
      blkR  <= '0;
      colR  <= '0;
    end else if (ctrl.start) begin
      remR <= startRow;
      quoR <= '0;
      colR <= '0;
    end else if (ctrl.divStep) begin
      remR <= remR - ROW_W'(SCAN_SP);
      quoR <= quoR + 1'b1;
    end else if (ctrl.divDone) begin
      partR <= remR[PART_W-1:0];
      bitR  <= quoR[2:0];
      blkR  <= quoR[4:3];
      colR  <= '0;
    end else if (ctrl.rowAdv) begin
      colR <= '0;
      if (partR == PART_W'(SCAN_SP - 1)) begin
        partR <= '0;
        bitR  <= bitR + 1'b1;
        if (bitR == 3'd7) blkR <= blkR + 1'b1;
      end else begin
        partR <= partR + 1'b1;
      end
    end else if (ctrl.colAdv) begin
      if (colR == COL_W'(PANEL_W - 1)) colR <= '0;
      else                             colR <= colR + 1'b1;
    end
  end

  // Logical byte index inside one copy; physical address interleaves copies
  assign logicalIdx = LOG_W'(blkR) * LOG_W'(BLK_BYTES)
                    + LOG_W'(partR) * LOG_W'(PANEL_W)
                    + LOG_W'(colR);
  assign memAddr = {logicalIdx, 1'b0};
  assign colIdx  = colR;
  assign partIdx = partR;
  assign bitSel  = bitR;
endmodule

// File: rtl/scroll_addr_gen.sv
module scroll_addr_gen
  import scroll_addr_pkg::*;
#(
  parameter int PANEL_W = 16,
  parameter int SCAN_SP = 4,
  localparam int ROW_W  = $clog2(32 * SCAN_SP),
  localparam int ADDR_W = $clog2(8 * SCAN_SP * PANEL_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadRow,
  input  logic [ROW_W-1:0]  startRow,
  input  logic              rowStep,
  input  logic              colStep,
  output logic              ready,
  output logic [ADDR_W-1:0] memAddr,
  output logic [2:0]        bitSel
);
  localparam int COL_W  = (PANEL_W > 1) ? $clog2(PANEL_W) : 1;
  localparam int PART_W = (SCAN_SP > 1) ? $clog2(SCAN_SP) : 1;

  dpCtrl_t           ctrl;
  logic              remGeSw;
  logic [COL_W-1:0]  colIdx;
  logic [PART_W-1:0] partIdx;

  scroll_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .loadRow (loadRow),
    .rowStep (rowStep),
    .colStep (colStep),
    .remGeSw (remGeSw),
    .ctrl    (ctrl),
    .ready   (ready)
  );

  scroll_dp #(.PANEL_W(PANEL_W), .SCAN_SP(SCAN_SP)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .startRow (startRow),
    .remGeSw  (remGeSw),
    .colIdx   (colIdx),
    .partIdx  (partIdx),
    .bitSel   (bitSel),
    .memAddr  (memAddr)
  );
endmodule

// File: rtl/scroll_addr_chk.sv
module scroll_addr_chk #(
  parameter int PANEL_W = 16,
  parameter int SCAN_SP = 4,
  localparam int COL_W  = (PANEL_W > 1) ? $clog2(PANEL_W) : 1,
  localparam int PART_W = (SCAN_SP > 1) ? $clog2(SCAN_SP) : 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              loadRow,
  input logic              rowStep,
  input logic              colStep,
  input logic              ready,
  input logic [COL_W-1:0]  colIdx,
  input logic [PART_W-1:0] partIdx,
  input logic [2:0]        bitSel
);
  p_load_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    loadRow |=> !ready);

  p_col_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ready && colStep && !rowStep && !loadRow && colIdx != COL_W'(PANEL_W - 1))
    |=> colIdx == COL_W'($past(colIdx) + 1'b1));

  p_col_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ready && colStep && !rowStep && !loadRow && colIdx == COL_W'(PANEL_W - 1))
    |=> colIdx == '0);

  p_part_wrap_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ready && rowStep && !loadRow && partIdx == PART_W'(SCAN_SP - 1))
    |=> (partIdx == '0 && bitSel == 3'($past(bitSel) + 1'b1)));

  p_row_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ready && rowStep && colStep && !loadRow) |=> colIdx == '0);

  p_busy_col_r10: assert property (@(posedge clk) disable iff (!rstN)
    !ready |-> colIdx == '0);

  p_load_first_r11: assert property (@(posedge clk) disable iff (!rstN)
    (loadRow && ready) |=> ($stable(bitSel) && $stable(partIdx)));
endmodule

bind scroll_addr_gen scroll_addr_chk #(.PANEL_W(PANEL_W), .SCAN_SP(SCAN_SP)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .loadRow (loadRow),
  .rowStep (rowStep),
  .colStep (colStep),
  .ready   (ready),
  .colIdx  (colIdx),
  .partIdx (partIdx),
  .bitSel  (bitSel)
);

// File: tb/scroll_addr_gen_tb.sv
module scroll_addr_gen_tb;
  localparam int PANEL_W  = 16;
  localparam int SCAN_SP  = 4;
  localparam int BLK_ROWS = 8 * SCAN_SP;
  localparam int TOT_ROWS = 4 * BLK_ROWS;
  localparam int ROW_W    = $clog2(TOT_ROWS);
  localparam int ADDR_W   = $clog2(8 * SCAN_SP * PANEL_W);

  logic clk = 0;
  logic rstN = 0;
  logic loadRow = 0;
  logic [ROW_W-1:0] startRow = '0;
  logic rowStep = 0;
  logic colStep = 0;
  logic ready;
  logic [ADDR_W-1:0] memAddr;
  logic [2:0] bitSel;

  int errors = 0;
  int checks = 0;
  int mRow = 0;
  int mCol = 0;
  int lat;

  always #10 clk = ~clk;

  scroll_addr_gen #(.PANEL_W(PANEL_W), .SCAN_SP(SCAN_SP)) u_dut (
    .clk(clk), .rstN(rstN), .loadRow(loadRow), .startRow(startRow),
    .rowStep(rowStep), .colStep(colStep), .ready(ready),
    .memAddr(memAddr), .bitSel(bitSel)
  );

  function automatic int expAddr(int r, int c);
    int blk;
    blk = (r / BLK_ROWS) % 4;
    return 2 * (blk * SCAN_SP * PANEL_W + (r % SCAN_SP) * PANEL_W + c);
  endfunction

  function automatic int expBit(int r);
    return (r % BLK_ROWS) / SCAN_SP;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkPos(string tag);
    check({tag, " R3 addr"}, int'(memAddr), expAddr(mRow, mCol));
    check({tag, " R4 bitSel"}, int'(bitSel), expBit(mRow));
  endtask

  // Load a row; strobesDuring holds row/col strobes high for the first busy cycle
  task automatic doLoad(int r, bit withStrobes, bit strobesDuring, output int n);
    @(negedge clk);
    loadRow = 1; startRow = ROW_W'(r);
    rowStep = withStrobes; colStep = withStrobes;
    @(posedge clk); n = 1;
    @(negedge clk);
    loadRow = 0;
    rowStep = strobesDuring; colStep = strobesDuring;
    check("R2 busy after load", int'(ready), 0);
    @(posedge clk); n++;
    @(negedge clk);
    rowStep = 0; colStep = 0;
    while (!ready && n < 1000) begin
      @(posedge clk); n++;
      @(negedge clk);
    end
    mRow = r; mCol = 0;
  endtask

  task automatic pulse(bit doRow, bit doCol);
    @(negedge clk);
    rowStep = doRow; colStep = doCol;
    @(posedge clk);
    @(negedge clk);
    rowStep = 0; colStep = 0;
    if (doRow) begin
      mRow = (mRow + 1) % TOT_ROWS; mCol = 0;
    end else if (doCol) begin
      mCol = (mCol + 1) % PANEL_W;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int r, k;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 ready in reset", int'(ready), 1);
    rstN = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 ready", int'(ready), 1);
    check("R1 addr", int'(memAddr), 0);
    check("R1 bitSel", int'(bitSel), 0);

    // Random start rows and strobe mixes (R3 R4 R5 R7 R9)
    for (int t = 0; t < 30; t++) begin
      r = int'($urandom % TOT_ROWS);
      doLoad(r, 0, 0, lat);
      check("R2 latency", lat, r / SCAN_SP + 2);
      checkPos("rand load");
      for (int s = 0; s < 20; s++) begin
        k = int'($urandom % 4);
        pulse(k == 1 || k == 2, k == 0 || k == 2);
        checkPos(k == 2 ? "R9 both strobes" : (k == 1 ? "R7 row step" : "R5 col step"));
      end
    end

    // R6 column wrap
    doLoad(5, 0, 0, lat);
    for (int c = 0; c < PANEL_W; c++) pulse(0, 1);
    check("R6 col wrap addr", int'(memAddr), expAddr(5, 0));

    // R7 partition wrap back to block start, bitSel up
    doLoad(SCAN_SP - 1, 0, 0, lat);
    pulse(0, 1);
    pulse(1, 0);
    check("R7 block start addr", int'(memAddr), 0);
    check("R7 bitSel up", int'(bitSel), 1);

    // R8 block crossing and full wrap
    doLoad(BLK_ROWS - 1, 0, 0, lat);
    check("R8 bitSel 7", int'(bitSel), 7);
    pulse(1, 0);
    check("R8 next block addr", int'(memAddr), 2 * SCAN_SP * PANEL_W);
    check("R8 next block bitSel", int'(bitSel), 0);
    doLoad(TOT_ROWS - 1, 0, 0, lat);
    pulse(1, 0);
    check("R8 wrap to row 0 addr", int'(memAddr), 0);
    check("R8 wrap to row 0 bitSel", int'(bitSel), 0);

    // R10 strobes while busy are ignored
    doLoad(3 * SCAN_SP + 2, 0, 1, lat);
    check("R10 busy strobes addr", int'(memAddr), expAddr(3 * SCAN_SP + 2, 0));
    check("R10 busy strobes bitSel", int'(bitSel), expBit(3 * SCAN_SP + 2));

    // R11 load beats strobes in the same cycle
    doLoad(2 * BLK_ROWS + 1, 1, 0, lat);
    check("R11 load priority addr", int'(memAddr), expAddr(2 * BLK_ROWS + 1, 0));
    check("R11 load priority latency", lat, (2 * BLK_ROWS + 1) / SCAN_SP + 2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule